// File: doc/BRIEF.md
# USB Frame Timer and Frame Counter

This block keeps full-speed USB frame timing for a host controller. It counts bit-rate ticks (one enable pulse per 12 MHz bit time) against a programmable frame interval, numbers frames with a 16-bit counter, and reports how many bit times remain in the current frame. At every frame boundary it copies the interval toggle into the remaining-time toggle and advances the frame number. It also steps a 3-bit delay counter that decides when the done-queue writeback event may fire. Its pulse outputs mark the start of a frame, a done writeback and a change of the frame number's top bit.

Frames are generated only while the controller's 2-bit functional state is operational (binary 10). Entering that state opens a new frame at once, and leaving it stops the count. Software reaches the block through a small word-wide register window with four slots. Slot 0 is the interval configuration, slot 1 the remaining-time readout, slot 2 the frame number and slot 3 the low-speed threshold. A transfer-completion strobe carrying its own 3-bit delay value lowers the delay counter.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, slot 0 reads interval 11999 (bits 13:0), largest-packet field 0x2778 (bits 30:16) and toggle 0 (bit 31). Slot 1 reads 0, slot 2 reads 0 and slot 3 reads 0x628.
- R2: A write to slot 0 stores bits 13:0 as the interval, bits 30:16 as the largest-packet field and bit 31 as the toggle. A read returns those three fields, with bits 15:14 reading 0.
- R3: A write to slot 3 stores bits 11:0 as the low-speed threshold, and a read returns it with the upper bits 0.
- R4: While operational, a frame lasts interval+1 ticks. `sof_evt` pulses for one cycle in the cycle after the clock edge that enters the operational state, and in the cycle after each frame boundary.
- R5: Slot 1 reads the remaining-time toggle in bit 31, with interval minus elapsed ticks in bits 13:0. Bits 13:0 read 0 when the state is not operational, when frame generation has not yet started, or when the elapsed count exceeds the interval. The next tick after such an overrun ends the frame.
- R6: At each frame boundary the remaining-time toggle takes the interval toggle, and the frame number in slot 2 increments modulo 65536. At no other time does the frame number change.
- R7: `list_slot` always equals bits 4:0 of the frame number.
- R8: `fno_evt` pulses together with `sof_evt` when bit 15 of the frame number changes at a boundary.
- R9: The delay counter starts at 7. A `td_done` strobe sets it to the smaller of its value and `td_delay`. When a boundary falls in the same cycle, the boundary update is applied first.
- R10: At a boundary with the delay counter at 0 and `wb_pending` low, `wb_evt` pulses with `sof_evt` and the counter returns to 7. Otherwise a counter value other than 0 or 7 decrements by one. `wb_evt` never fires while `wb_pending` is high.
- R11: Outside the operational state, ticks are ignored and the frame number holds. On re-entry a new frame starts from zero elapsed ticks.
- R12: Writes to slots 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per USB bit time |
| hc_state | input | 2 | Functional state: 00 reset, 01 resume, 10 operational, 11 suspend |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register slot select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected slot (combinational) |
| td_done | input | 1 | A transfer completed this cycle |
| td_delay | input | 3 | Interrupt delay field of the completed transfer |
| wb_pending | input | 1 | Writeback interrupt already pending |
| sof_evt | output | 1 | Start-of-frame pulse |
| wb_evt | output | 1 | Done-writeback pulse |
| fno_evt | output | 1 | Frame number top-bit change pulse |
| list_slot | output | 5 | Periodic list slot of the current frame |

## Verification
The assertions assume that `hc_state` is held low during reset and that `wb_pending` is a clean level sampled at the clock. They also assume the interval is never made so small that the elapsed count would wrap, and the 14-bit counter rules that out. The stimulus changes the functional state only rarely, writes intervals of at most 24 ticks so that boundaries happen often, and drives every input at the falling edge. It includes one long run with a zero interval that takes the frame number through a full wrap.

// File: rtl/ft_pkg.sv
package ft_pkg;

    typedef enum logic [1:0] {
        HC_RESET   = 2'b00,
        HC_RESUME  = 2'b01,
        HC_OPER    = 2'b10,
        HC_SUSPEND = 2'b11
    } hc_state_e;

    typedef enum logic [1:0] {
        SLOT_INTERVAL = 2'd0,
        SLOT_REMAIN   = 2'd1,
        SLOT_FNUM     = 2'd2,
        SLOT_LSTH     = 2'd3
    } reg_slot_e;

    localparam int REG_W   = 32;
    localparam int MPS_LSB = 16;
    localparam int TGL_BIT = 31;

endpackage

// File: rtl/ft_regs.sv
module ft_regs
    import ft_pkg::*;
#(
    parameter int              FI_W    = 14,
    parameter int              MPS_W   = 15,
    parameter int              LST_W   = 12,
    parameter logic [FI_W-1:0] FI_RST  = 14'd11999,
    parameter logic [MPS_W-1:0] MPS_RST = 15'h2778,
    parameter logic [LST_W-1:0] LST_RST = 12'h628
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wdata,
    output logic [FI_W-1:0]  cfg_fi,
    output logic [MPS_W-1:0] cfg_mps,
    output logic             cfg_tgl,
    output logic [LST_W-1:0] cfg_lst
);

    typedef struct packed {
        logic [FI_W-1:0]  fi;
        logic [MPS_W-1:0] mps;
        logic             tgl;
        logic [LST_W-1:0] lst;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                SLOT_INTERVAL: begin
                    cfg_d.fi  = wdata[FI_W-1:0];
                    cfg_d.mps = wdata[MPS_LSB +: MPS_W];
                    cfg_d.tgl = wdata[TGL_BIT];
                end
                SLOT_LSTH: cfg_d.lst = wdata[LST_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.fi  <= FI_RST;
            cfg_q.mps <= MPS_RST;
            cfg_q.tgl <= 1'b0;
            cfg_q.lst <= LST_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_fi  = cfg_q.fi;
    assign cfg_mps = cfg_q.mps;
    assign cfg_tgl = cfg_q.tgl;
    assign cfg_lst = cfg_q.lst;

endmodule

// File: rtl/ft_bitcnt.sv
module ft_bitcnt #(
    parameter int FI_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            oper,
    input  logic            bit_tick,
    input  logic [FI_W-1:0] interval,
    output logic [FI_W-1:0] elapsed,
    output logic            running,
    output logic            frame_open,
    output logic            boundary
);

    typedef struct packed {
        logic            run;
        logic [FI_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic start;

    always_comb begin
        cnt_d    = cnt_q;
        start    = oper && !cnt_q.run;
        boundary = oper && cnt_q.run && bit_tick && (cnt_q.cnt >= interval);
        if (!oper) begin
            cnt_d.run = 1'b0;
            cnt_d.cnt = '0;
        end else if (start) begin
            cnt_d.run = 1'b1;
            cnt_d.cnt = '0;
        end else if (bit_tick) begin
            cnt_d.cnt = boundary ? '0 : cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.run <= 1'b0;
            cnt_q.cnt <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign elapsed    = cnt_q.cnt;
    assign running    = cnt_q.run;
    assign frame_open = start || boundary;

endmodule

// File: rtl/ft_donedly.sv
module ft_donedly #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             td_done,
    input  logic [DLY_W-1:0] td_delay,
    input  logic             wb_pending,
    output logic             wb_fire
);

    localparam logic [DLY_W-1:0] DLY_IDLE = '1;

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } dly_t;

    dly_t dly_d, dly_q;
    logic [DLY_W-1:0] after_bnd;

    always_comb begin
        after_bnd = dly_q.cnt;
        wb_fire   = 1'b0;
        if (boundary) begin
            if (dly_q.cnt == '0 && !wb_pending) begin
                wb_fire   = 1'b1;
                after_bnd = DLY_IDLE;
            end else if (dly_q.cnt != '0 && dly_q.cnt != DLY_IDLE) begin
                after_bnd = dly_q.cnt - 1'b1;
            end
        end
        dly_d.cnt = (td_done && td_delay < after_bnd) ? td_delay : after_bnd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q.cnt <= DLY_IDLE;
        else        dly_q     <= dly_d;
    end

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import ft_pkg::*;
#(
    parameter int FI_W   = 14,
    parameter int MPS_W  = 15,
    parameter int LST_W  = 12,
    parameter int FN_W   = 16,
    parameter int DLY_W  = 3,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [1:0]        hc_state,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              td_done,
    input  logic [DLY_W-1:0]  td_delay,
    input  logic              wb_pending,
    output logic              sof_evt,
    output logic              wb_evt,
    output logic              fno_evt,
    output logic [SLOT_W-1:0] list_slot
);

    localparam int FN_MSB = FN_W - 1;

    typedef struct packed {
        logic [FN_W-1:0] fn;
        logic            rem_tgl;
        logic            sof;
        logic            wb;
        logic            fno;
    } frm_t;

    frm_t frm_d, frm_q;

    logic [FI_W-1:0]  cfg_fi;
    logic [MPS_W-1:0] cfg_mps;
    logic             cfg_tgl;
    logic [LST_W-1:0] cfg_lst;
    logic [FI_W-1:0]  elapsed;
    logic             running;
    logic             frame_open;
    logic             boundary;
    logic             wb_fire;
    logic             oper;
    logic [FI_W-1:0]  rem_lo;
    logic [FN_W-1:0]  frame_num;

    assign oper = (hc_state == HC_OPER);

    ft_regs #(
        .FI_W (FI_W),
        .MPS_W(MPS_W),
        .LST_W(LST_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_addr(reg_addr),
        .wdata  (reg_wdata),
        .cfg_fi (cfg_fi),
        .cfg_mps(cfg_mps),
        .cfg_tgl(cfg_tgl),
        .cfg_lst(cfg_lst)
    );

    ft_bitcnt #(
        .FI_W(FI_W)
    ) u_bitcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .oper      (oper),
        .bit_tick  (bit_tick),
        .interval  (cfg_fi),
        .elapsed   (elapsed),
        .running   (running),
        .frame_open(frame_open),
        .boundary  (boundary)
    );

    ft_donedly #(
        .DLY_W(DLY_W)
    ) u_donedly (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .td_done   (td_done),
        .td_delay  (td_delay),
        .wb_pending(wb_pending),
        .wb_fire   (wb_fire)
    );

    always_comb begin
        frm_d     = frm_q;
        frm_d.sof = frame_open;
        frm_d.wb  = wb_fire;
        frm_d.fno = 1'b0;
        if (boundary) begin
            frm_d.rem_tgl = cfg_tgl;
            frm_d.fn      = frm_q.fn + 1'b1;
            frm_d.fno     = frm_d.fn[FN_MSB] ^ frm_q.fn[FN_MSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    always_comb begin
        rem_lo = '0;
        if (oper && running && elapsed <= cfg_fi) rem_lo = cfg_fi - elapsed;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SLOT_INTERVAL: begin
                reg_rdata[FI_W-1:0]          = cfg_fi;
                reg_rdata[MPS_LSB +: MPS_W]  = cfg_mps;
                reg_rdata[TGL_BIT]           = cfg_tgl;
            end
            SLOT_REMAIN: begin
                reg_rdata[FI_W-1:0] = rem_lo;
                reg_rdata[TGL_BIT]  = frm_q.rem_tgl;
            end
            SLOT_FNUM: reg_rdata[FN_W-1:0]  = frm_q.fn;
            default:   reg_rdata[LST_W-1:0] = cfg_lst;
        endcase
    end

    assign frame_num = frm_q.fn;
    assign sof_evt   = frm_q.sof;
    assign wb_evt    = frm_q.wb;
    assign fno_evt   = frm_q.fno;
    assign list_slot = frm_q.fn[SLOT_W-1:0];

endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
    parameter int FI_W = 14,
    parameter int FN_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      hc_state,
    input logic            wb_pending,
    input logic            sof_evt,
    input logic            wb_evt,
    input logic            fno_evt,
    input logic [FN_W-1:0] frame_num,
    input logic [FI_W-1:0] fi,
    input logic [FI_W-1:0] rem_lo
);

    AST_SOF_NEEDS_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        sof_evt |-> $past(hc_state) == 2'b10); // R4

    AST_FN_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_num != $past(frame_num)) |-> (sof_evt && frame_num == $past(frame_num) + 1'b1)); // R6

    AST_REM_WITHIN_FI: assert property (@(posedge clk) disable iff (!rst_n)
        rem_lo <= fi); // R5

    AST_FNO_ON_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fno_evt |-> (sof_evt && frame_num[FN_W-1] != $past(frame_num[FN_W-1]))); // R8

    AST_WB_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wb_evt |-> !$past(wb_pending)); // R10

    AST_WB_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_evt |-> sof_evt); // R10

endmodule

bind usb_frame_timer ft_checker #(
    .FI_W(FI_W),
    .FN_W(FN_W)
) u_ft_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hc_state  (hc_state),
    .wb_pending(wb_pending),
    .sof_evt   (sof_evt),
    .wb_evt    (wb_evt),
    .fno_evt   (fno_evt),
    .frame_num (frame_num),
    .fi        (cfg_fi),
    .rem_lo    (rem_lo)
);

// File: tb/tb_usb_frame_timer.sv
module tb_usb_frame_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [1:0]  hc_state = 2'b00;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        td_done = 1'b0;
    logic [2:0]  td_delay = 3'd0;
    logic        wb_pending = 1'b0;
    logic        sof_evt, wb_evt, fno_evt;
    logic [4:0]  list_slot;

    int n_checks = 0;
    int n_errs   = 0;

    // reference model state
    logic [13:0] m_fi  = 14'd11999;
    logic [14:0] m_mps = 15'h2778;
    logic        m_tgl = 1'b0;
    logic [11:0] m_lst = 12'h628;
    logic        m_run = 1'b0;
    logic [13:0] m_cnt = '0;
    logic [15:0] m_fn  = '0;
    logic        m_rtg = 1'b0;
    logic [2:0]  m_dly = 3'd7;
    logic        m_sof = 1'b0, m_wb = 1'b0, m_fno = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_frame_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .hc_state  (hc_state),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .td_done   (td_done),
        .td_delay  (td_delay),
        .wb_pending(wb_pending),
        .sof_evt   (sof_evt),
        .wb_evt    (wb_evt),
        .fno_evt   (fno_evt),
        .list_slot (list_slot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        logic [13:0] rl;
        rl = (hc_state == 2'b10 && m_run && m_cnt <= m_fi) ? m_fi - m_cnt : 14'd0;
        case (a)
            2'd0:    return {m_tgl, m_mps, 2'b00, m_fi};
            2'd1:    return {m_rtg, 17'd0, rl};
            2'd2:    return {16'd0, m_fn};
            default: return {20'd0, m_lst};
        endcase
    endfunction

    task automatic model_next();
        logic        oper, start, bnd;
        logic [15:0] nfn;
        logic [2:0]  c;
        logic        nwb;
        oper  = (hc_state == 2'b10);
        start = oper && !m_run;
        bnd   = oper && m_run && bit_tick && (m_cnt >= m_fi);
        nfn   = bnd ? m_fn + 16'd1 : m_fn;
        c     = m_dly;
        nwb   = 1'b0;
        if (bnd) begin
            if (c == 3'd0 && !wb_pending) begin
                nwb = 1'b1;
                c   = 3'd7;
            end else if (c != 3'd0 && c != 3'd7) begin
                c = c - 3'd1;
            end
        end
        if (td_done && td_delay < c) c = td_delay;
        m_sof = start || bnd;
        m_wb  = nwb;
        m_fno = bnd && (nfn[15] != m_fn[15]);
        if (bnd) m_rtg = m_tgl;
        m_fn  = nfn;
        m_dly = c;
        if (!oper) begin
            m_run = 1'b0;
            m_cnt = '0;
        end else if (start) begin
            m_run = 1'b1;
            m_cnt = '0;
        end else if (bit_tick) begin
            m_cnt = bnd ? 14'd0 : m_cnt + 14'd1;
        end
        if (reg_wr) begin
            if (reg_addr == 2'd0) begin
                m_fi  = reg_wdata[13:0];
                m_mps = reg_wdata[30:16];
                m_tgl = reg_wdata[31];
            end else if (reg_addr == 2'd3) begin
                m_lst = reg_wdata[11:0];
            end
        end
    endtask

    task automatic check_outputs();
        string tag;
        check("R4,R11 sof_evt", {31'd0, sof_evt}, {31'd0, m_sof});
        check("R9,R10 wb_evt", {31'd0, wb_evt}, {31'd0, m_wb});
        check("R8 fno_evt", {31'd0, fno_evt}, {31'd0, m_fno});
        check("R7 list_slot", {27'd0, list_slot}, {27'd0, m_fn[4:0]});
        case (reg_addr)
            2'd0:    tag = "R2 interval slot";
            2'd1:    tag = "R5 remaining slot";
            2'd2:    tag = "R6,R11 frame number slot";
            default: tag = "R3 threshold slot";
        endcase
        check(tag, reg_rdata, exp_rdata(reg_addr));
    endtask

    // one clock: model the coming edge, let it happen, compare at the falling edge
    task automatic step();
        model_next();
        @(posedge clk);
        @(negedge clk);
        check_outputs();
        reg_wr  = 1'b0;
        td_done = 1'b0;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        step();
    endtask

    initial begin
        int sof_cnt, wb_cnt, fno_cnt;
        logic [15:0] fn_hold;
        void'($urandom(32'd24681));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        reg_addr = 2'd0; #1;
        check("R1 interval reset", reg_rdata, {1'b0, 15'h2778, 2'b00, 14'd11999});
        reg_addr = 2'd1; #1;
        check("R1 remaining reset", reg_rdata, 32'd0);
        reg_addr = 2'd2; #1;
        check("R1 frame number reset", reg_rdata, 32'd0);
        reg_addr = 2'd3; #1;
        check("R1 threshold reset", reg_rdata, 32'h0000_0628);
        check("R1 sof idle", {31'd0, sof_evt}, 32'd0);

        // R12: read-only slots ignore writes
        write_reg(2'd2, 32'hFFFF_FFFF);
        write_reg(2'd1, 32'hFFFF_FFFF);
        reg_addr = 2'd2; #1;
        check("R12 frame number after write", reg_rdata, 32'd0);
        reg_addr = 2'd1; #1;
        check("R12 remaining after write", reg_rdata, 32'd0);

        // R2 and R3: field layout
        write_reg(2'd0, 32'hA5A5_C009);
        reg_addr = 2'd0; #1;
        check("R2 interval layout", reg_rdata, 32'hA5A5_0009);
        write_reg(2'd3, 32'hFFFF_F3C1);
        reg_addr = 2'd3; #1;
        check("R3 threshold layout", reg_rdata, 32'h0000_03C1);

        // R4: frame length interval+1 with a tick every cycle
        reg_addr = 2'd1;
        hc_state = 2'b10;
        bit_tick = 1'b1;
        sof_cnt  = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (sof_evt) sof_cnt++;
        end
        check("R4 sof count in 40 cycles", sof_cnt, 4);

        // R5: shrink the interval below the elapsed count mid-frame
        repeat (4) step();
        write_reg(2'd0, 32'h8000_0003);
        reg_addr = 2'd1;
        bit_tick = 1'b0;
        step();
        check("R5 overrun reads zero", {18'd0, reg_rdata[13:0]}, 32'd0);
        bit_tick = 1'b1;
        step();
        check("R5 overrun ends frame", {31'd0, sof_evt}, 32'd1);

        // R11: suspended, ticks ignored
        reg_addr = 2'd2; #1;
        fn_hold  = reg_rdata[15:0];
        hc_state = 2'b11;
        sof_cnt  = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (sof_evt) sof_cnt++;
        end
        check("R11 no sof when suspended", sof_cnt, 0);
        check("R11 frame number held", {16'd0, reg_rdata[15:0]}, {16'd0, fn_hold});
        hc_state = 2'b10;
        step();
        check("R11 re-entry opens frame", {31'd0, sof_evt}, 32'd1);

        // R9 and R10: delay counter and pending gate
        write_reg(2'd0, 32'h0000_0004);
        repeat (6) step();
        td_done  = 1'b1;
        td_delay = 3'd2;
        step();
        wb_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (wb_evt) wb_cnt++;
        end
        check("R9 writeback after delay 2", wb_cnt, 1);
        td_done    = 1'b1;
        td_delay   = 3'd0;
        wb_pending = 1'b1;
        step();
        wb_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            wb_pending = 1'b1;
            step();
            if (wb_evt) wb_cnt++;
        end
        check("R10 no writeback while pending", wb_cnt, 0);
        wb_pending = 1'b0;
        wb_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (wb_evt) wb_cnt++;
        end
        check("R10 writeback once released", wb_cnt, 1);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            if ($urandom_range(0, 63) == 0) hc_state = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) hc_state = 2'b10;
            bit_tick   = ($urandom_range(0, 1) == 1);
            td_done    = ($urandom_range(0, 9) == 0);
            td_delay   = 3'($urandom_range(0, 7));
            wb_pending = ($urandom_range(0, 4) == 0);
            reg_addr   = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 31) == 0) begin
                wd = $urandom;
                if (reg_addr == 2'd0) wd[13:0] = 14'($urandom_range(0, 24));
                reg_wr    = 1'b1;
                reg_wdata = wd;
            end
            step();
        end

        // R6 and R8: full wrap of the frame number with one-tick frames
        wb_pending = 1'b0;
        hc_state   = 2'b10;
        bit_tick   = 1'b1;
        write_reg(2'd0, 32'h0000_0000);
        reg_addr = 2'd2;
        repeat (3) step();
        fn_hold = reg_rdata[15:0];
        fno_cnt = 0;
        for (int i = 0; i < 65536; i++) begin
            step();
            if (fno_evt) fno_cnt++;
        end
        check("R8 top-bit changes per wrap", fno_cnt, 2);
        check("R6 frame number modulo 65536", {16'd0, reg_rdata[15:0]}, {16'd0, fn_hold});

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule